// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block prepares the segment table for a pending data transfer. A start pulse hands it a pointer to a chain of descriptors in memory, a 16-bit list size in bytes, and one address/length pair supplied with the request. The walker fetches each 8-byte descriptor (address word, then length word) over a simple request/acknowledge read port. Data descriptors go into a local table of address/length pairs.

Some descriptors are links rather than data. A length above a threshold redirects the read pointer to another list, and after that the walk continues until it meets a terminating zero length. A list size below one descriptor means no memory is read: the table takes the single pair supplied with the request. When the walk ends, a one-cycle done pulse presents the number of valid entries and an overflow flag. The transfer engine then reads the table through a registered read port.

Top module: `sgl_walker`

## Requirements
- R1: After reset, busy, done, overflow and mem_req are 0 and entry_count is 0.
- R2: The nominal descriptor count is list_bytes shifted right by 3; the low three bits of list_bytes are ignored. Each descriptor at pointer P is read as the address word at P, then the length word at P+4. Only one read is outstanding at a time, and mem_req stays high with mem_addr unchanged until mem_ack.
- R3: When the nominal count is 0 (list_bytes below 8), no memory read is made. Entry 0 takes emb_addr/emb_len and entry_count becomes 1.
- R4: A descriptor whose length is 1 to 0x1000 inclusive is a data segment. It is stored at the next table index, and the read pointer advances by 8.
- R5: A descriptor whose length is 0 ends the walk at once and is not stored.
- R6: A descriptor whose length is above 0x1000 is a link. Its address word becomes the read pointer, nothing is stored, and link mode is entered.
- R7: In link mode the walk continues past the nominal count and ends only on a zero length or overflow.
- R8: Outside link mode the walk ends once the number of stored entries reaches the nominal count.
- R9: An attempt to store a data descriptor while 16 entries are held ends the walk with overflow=1 and entry_count=16. Exactly 16 stored entries give overflow=0.
- R10: done is a one-cycle pulse in the cycle busy falls. entry_count and overflow are updated with it and held until the next walk ends. A start while busy is ignored.
- R11: rd_addr/rd_len show the table entry selected by rd_idx one clock after rd_idx is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (ignored while busy) |
| start_ptr | input | 32 | Byte address of the first descriptor |
| list_bytes | input | 16 | List size in bytes; divided by 8 for the descriptor count |
| emb_addr | input | 32 | Address used when the list is empty |
| emb_len | input | 32 | Length used when the list is empty |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 32 | Read byte address |
| mem_ack | input | 1 | Read acknowledge; mem_rdata valid in the same cycle |
| mem_rdata | input | 32 | Read data word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| entry_count | output | 5 | Number of valid table entries |
| overflow | output | 1 | Last walk ran out of table space |
| rd_idx | input | 4 | Table read index |
| rd_addr | output | 32 | Address field of the selected entry |
| rd_len | output | 32 | Length field of the selected entry |

## Verification
The assertions check on every cycle that a read request is held steady until it is acknowledged and that no request appears while idle. They also check that done is a single pulse matching the fall of busy, that entry_count never exceeds the table depth, and that overflow only appears with a full table. Other behaviours can only be shown by the bench's scenarios, because the bench has to know the contents of memory. These are the order of the address stream, link redirection, continuation past the nominal count, stopping on a zero length, the empty-list substitution, and the stored table contents.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EMB,
    ST_RDA,
    ST_RDL,
    ST_EVAL,
    ST_NEXT
  } walk_st_t;
endpackage

// File: rtl/sgl_table.sv
module sgl_table #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     waddr,
  input  logic [W-1:0]     wlen,
  input  logic [IDX_W-1:0] ridx,
  output logic [W-1:0]     raddr,
  output logic [W-1:0]     rlen
);
  // Plain synchronous-read array, no reset, so it maps onto block RAM.
  logic [2*W-1:0] mem [DEPTH];
  logic [2*W-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= {waddr, wlen};
    rd_q <= mem[ridx];
  end

  assign raddr = rd_q[2*W-1:W];
  assign rlen  = rd_q[W-1:0];
endmodule

// File: rtl/sgl_fsm.sv
module sgl_fsm
  import sgl_pkg::*;
#(
  parameter int          W          = 32,
  parameter int          ND_W       = 13,
  parameter int          DEPTH      = 16,
  parameter int          IDX_W      = 4,
  parameter int          CNT_W      = 5,
  parameter logic [31:0] LINK_LIMIT = 32'h1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     start_ptr,
  input  logic [ND_W-1:0]  desc_cnt,
  input  logic [W-1:0]     emb_addr,
  input  logic [W-1:0]     emb_len,
  output logic             mem_req,
  output logic [W-1:0]     mem_addr,
  input  logic             mem_ack,
  input  logic [W-1:0]     mem_rdata,
  output logic             tab_we,
  output logic [IDX_W-1:0] tab_widx,
  output logic [W-1:0]     tab_waddr,
  output logic [W-1:0]     tab_wlen,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] entry_count,
  output logic             overflow
);
  walk_st_t         st;
  logic [W-1:0]     ptr;
  logic [W-1:0]     a_word;
  logic [W-1:0]     l_word;
  logic [ND_W-1:0]  n_desc;
  logic [CNT_W-1:0] idx;
  logic             link;
  logic             more;

  assign mem_req = (st == ST_RDA) || (st == ST_RDL);
  assign busy    = (st != ST_IDLE);
  // Keep fetching while links are being followed or the nominal count is not reached.
  assign more    = link || (32'(idx) < 32'(n_desc));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      ptr         <= '0;
      a_word      <= '0;
      l_word      <= '0;
      n_desc      <= '0;
      idx         <= '0;
      link        <= 1'b0;
      mem_addr    <= '0;
      tab_we      <= 1'b0;
      tab_widx    <= '0;
      tab_waddr   <= '0;
      tab_wlen    <= '0;
      done        <= 1'b0;
      entry_count <= '0;
      overflow    <= 1'b0;
    end else begin
      done   <= 1'b0;
      tab_we <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            ptr    <= start_ptr;
            n_desc <= desc_cnt;
            idx    <= '0;
            link   <= 1'b0;
            if (desc_cnt == '0) begin
              tab_we    <= 1'b1;
              tab_widx  <= '0;
              tab_waddr <= emb_addr;
              tab_wlen  <= emb_len;
              st        <= ST_EMB;
            end else begin
              mem_addr <= start_ptr;
              st       <= ST_RDA;
            end
          end
        end
        ST_EMB: begin
          st          <= ST_IDLE;
          done        <= 1'b1;
          entry_count <= CNT_W'(1);
          overflow    <= 1'b0;
        end
        ST_RDA: begin
          if (mem_ack) begin
            a_word   <= mem_rdata;
            mem_addr <= ptr + W'(4);
            st       <= ST_RDL;
          end
        end
        ST_RDL: begin
          if (mem_ack) begin
            l_word <= mem_rdata;
            st     <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (l_word == '0) begin
            st          <= ST_IDLE;
            done        <= 1'b1;
            entry_count <= idx;
            overflow    <= 1'b0;
          end else if (l_word > W'(LINK_LIMIT)) begin
            ptr  <= a_word;
            link <= 1'b1;
            st   <= ST_NEXT;
          end else if (idx == CNT_W'(DEPTH)) begin
            st          <= ST_IDLE;
            done        <= 1'b1;
            entry_count <= idx;
            overflow    <= 1'b1;
          end else begin
            tab_we    <= 1'b1;
            tab_widx  <= idx[IDX_W-1:0];
            tab_waddr <= a_word;
            tab_wlen  <= l_word;
            idx       <= idx + CNT_W'(1);
            ptr       <= ptr + W'(8);
            st        <= ST_NEXT;
          end
        end
        ST_NEXT: begin
          if (more) begin
            mem_addr <= ptr;
            st       <= ST_RDA;
          end else begin
            st          <= ST_IDLE;
            done        <= 1'b1;
            entry_count <= idx;
            overflow    <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgl_walker.sv
module sgl_walker #(
  parameter int          W          = 32,
  parameter int          BC_W       = 16,
  parameter int          DEPTH      = 16,
  parameter logic [31:0] LINK_LIMIT = 32'h1000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [W-1:0]               start_ptr,
  input  logic [BC_W-1:0]            list_bytes,
  input  logic [W-1:0]               emb_addr,
  input  logic [W-1:0]               emb_len,
  output logic                       mem_req,
  output logic [W-1:0]               mem_addr,
  input  logic                       mem_ack,
  input  logic [W-1:0]               mem_rdata,
  output logic                       busy,
  output logic                       done,
  output logic [$clog2(DEPTH+1)-1:0] entry_count,
  output logic                       overflow,
  input  logic [$clog2(DEPTH)-1:0]   rd_idx,
  output logic [W-1:0]               rd_addr,
  output logic [W-1:0]               rd_len
);
  localparam int ND_W  = BC_W - 3;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             tab_we;
  logic [IDX_W-1:0] tab_widx;
  logic [W-1:0]     tab_waddr;
  logic [W-1:0]     tab_wlen;
  logic             unused_low_bits;

  // Each descriptor is eight bytes, so the three low bits of the size carry no count.
  assign unused_low_bits = ^list_bytes[2:0];

  sgl_fsm #(
    .W(W), .ND_W(ND_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .LINK_LIMIT(LINK_LIMIT)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_ptr  (start_ptr),
    .desc_cnt   (list_bytes[BC_W-1:3]),
    .emb_addr   (emb_addr),
    .emb_len    (emb_len),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .tab_we     (tab_we),
    .tab_widx   (tab_widx),
    .tab_waddr  (tab_waddr),
    .tab_wlen   (tab_wlen),
    .busy       (busy),
    .done       (done),
    .entry_count(entry_count),
    .overflow   (overflow)
  );

  sgl_table #(.W(W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_tab (
    .clk  (clk),
    .we   (tab_we),
    .widx (tab_widx),
    .waddr(tab_waddr),
    .wlen (tab_wlen),
    .ridx (rd_idx),
    .raddr(rd_addr),
    .rlen (rd_len)
  );
endmodule

// File: rtl/sgl_walker_chk.sv
module sgl_walker_chk #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic             mem_ack,
  input logic [W-1:0]     mem_addr,
  input logic [CNT_W-1:0] entry_count,
  input logic             overflow
);
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r10_done_at_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r9_count_bound: assert property (@(posedge clk) disable iff (rst)
    entry_count <= CNT_W'(DEPTH));

  a_r9_ovf_full: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (entry_count == CNT_W'(DEPTH)));
endmodule

bind sgl_walker sgl_walker_chk #(.W(W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_sgl_walker.sv
module tb_sgl_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [31:0] start_ptr;
  logic [15:0] list_bytes;
  logic [31:0] emb_addr;
  logic [31:0] emb_len;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        busy;
  logic        done;
  logic [4:0]  entry_count;
  logic        overflow;
  logic [3:0]  rd_idx;
  logic [31:0] rd_addr;
  logic [31:0] rd_len;

  always #5 clk = ~clk;

  sgl_walker dut (.*);

  int checks = 0;
  int errors = 0;

  logic [31:0] mem_img [logic [31:0]];
  logic [31:0] exp_q[$];
  logic [31:0] ta [16];
  logic [31:0] tl [16];
  int          exp_cnt;
  bit          exp_ovf;
  int          wait_cnt;

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return mem_img.exists(a) ? mem_img[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] p, input logic [31:0] a, input logic [31:0] l);
    mem_img[p]     = a;
    mem_img[p + 4] = l;
  endtask

  // Memory responder: latency varies with the address, one acknowledge per request.
  always @(posedge clk) begin
    if (rst) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= int'(mem_addr[4:2] % 3)) begin
        mem_ack   <= 1'b1;
        mem_rdata <= rdw(mem_addr);
        wait_cnt  <= 0;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  // Reference model of the walk: expected read stream and table contents.
  task automatic model(input logic [31:0] p0, input logic [15:0] b,
                       input logic [31:0] ea, input logic [31:0] el);
    int n = int'(b) / 8;
    int i = 0;
    bit lk = 1'b0;
    logic [31:0] p = p0;
    logic [31:0] a;
    logic [31:0] l;
    exp_q.delete();
    exp_ovf = 1'b0;
    if (n == 0) begin
      ta[0] = ea; tl[0] = el; exp_cnt = 1;
      return;
    end
    while (i < n || lk) begin
      exp_q.push_back(p);
      exp_q.push_back(p + 4);
      a = rdw(p);
      l = rdw(p + 4);
      if (l == 0) break;
      if (l > 32'h1000) begin
        p = a; lk = 1'b1;
        continue;
      end
      if (i == 16) begin
        exp_ovf = 1'b1;
        break;
      end
      ta[i] = a; tl[i] = l;
      i++;
      p += 8;
    end
    exp_cnt = i;
  endtask

  // Compare every acknowledged read against the model's next expected address (R2).
  always @(negedge clk) begin
    if (!rst && mem_req && mem_ack) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected read", 64'(mem_addr), 64'h0);
      else begin
        chk(mem_addr == exp_q[0], "R2", "read address order", 64'(mem_addr), 64'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic run_walk(input logic [31:0] p, input logic [15:0] b,
                          input logic [31:0] ea, input logic [31:0] el,
                          input bit poke, input string tag);
    bit seen = 1'b0;
    model(p, b, ea, el);
    @(negedge clk);
    start = 1'b1; start_ptr = p; list_bytes = b; emb_addr = ea; emb_len = el;
    @(negedge clk);
    start = 1'b0; start_ptr = 32'hDEAD_0000; list_bytes = 16'h0008;
    for (int cyc = 0; cyc < 5000; cyc++) begin
      if (poke && cyc == 3) begin
        start = 1'b1; list_bytes = 16'h0; emb_addr = 32'hBAD0; emb_len = 32'h77;
      end
      if (poke && cyc == 4) start = 1'b0;
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        break;
      end
    end
    chk(seen, "R10", {tag, " done pulse seen"}, 64'(seen), 64'h1);
    chk(!busy, "R10", {tag, " busy low with done"}, 64'(busy), 64'h0);
    chk(entry_count == 5'(exp_cnt), tag, "entry count", 64'(entry_count), 64'(exp_cnt));
    chk(overflow == exp_ovf, tag, "overflow flag", 64'(overflow), 64'(exp_ovf));
    chk(exp_q.size() == 0, "R2", {tag, " all expected reads issued"}, 64'(exp_q.size()), 64'h0);
    @(negedge clk);
    chk(!done, "R10", {tag, " done lasts one cycle"}, 64'(done), 64'h0);
    for (int k = 0; k < exp_cnt && k < 16; k++) begin
      rd_idx = 4'(k);
      @(negedge clk);
      chk(rd_addr == ta[k], tag, "R11 table read address", 64'(rd_addr), 64'(ta[k]));
      chk(rd_len == tl[k], tag, "R11 table read length", 64'(rd_len), 64'(tl[k]));
    end
    chk(entry_count == 5'(exp_cnt), "R10", {tag, " count held after walk"},
        64'(entry_count), 64'(exp_cnt));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; start = 1'b0; start_ptr = '0; list_bytes = '0;
    emb_addr = '0; emb_len = '0; rd_idx = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", 64'(busy), 64'h0);
    chk(!done, "R1", "done after reset", 64'(done), 64'h0);
    chk(!mem_req, "R1", "mem_req after reset", 64'(mem_req), 64'h0);
    chk(entry_count == 0, "R1", "count after reset", 64'(entry_count), 64'h0);
    chk(!overflow, "R1", "overflow after reset", 64'(overflow), 64'h0);

    // Plain list; a fourth valid descriptor follows but lies past the count (R4, R8).
    put(32'h100, 32'h1000_0000, 32'h200);
    put(32'h108, 32'h1000_4000, 32'h1000);
    put(32'h110, 32'h1000_8000, 32'h1);
    put(32'h118, 32'h1000_C000, 32'h40);
    run_walk(32'h100, 16'd24, 32'h0, 32'h0, 1'b0, "R4");
    run_walk(32'h100, 16'd30, 32'h0, 32'h0, 1'b0, "R8");
    run_walk(32'h100, 16'd24, 32'h0, 32'h0, 1'b1, "R10");

    // Zero length in the middle ends the walk (R5).
    put(32'h400, 32'h2000_0000, 32'h10);
    put(32'h408, 32'h2000_1000, 32'h0);
    put(32'h410, 32'h2000_2000, 32'h20);
    run_walk(32'h400, 16'd24, 32'h0, 32'h0, 1'b0, "R5");

    // Link after one data entry, then three more past the nominal count (R6, R7).
    put(32'h800, 32'h3000_0000, 32'h80);
    put(32'h808, 32'h900, 32'h1001);
    put(32'h900, 32'h3000_1000, 32'h100);
    put(32'h908, 32'h3000_2000, 32'h200);
    put(32'h910, 32'h3000_3000, 32'h300);
    put(32'h918, 32'h0, 32'h0);
    run_walk(32'h800, 16'd16, 32'h0, 32'h0, 1'b0, "R6");

    // Link as the very first descriptor with a nominal count of one (R7).
    put(32'hA00, 32'hB00, 32'hFFFF_FFFF);
    put(32'hB00, 32'h3100_0000, 32'h10);
    put(32'hB08, 32'h3100_0100, 32'h20);
    put(32'hB10, 32'h0, 32'h0);
    run_walk(32'hA00, 16'd8, 32'h0, 32'h0, 1'b0, "R7");

    // Table capacity (R9).
    for (int k = 0; k < 20; k++)
      put(32'h2000 + 32'(k * 8), 32'h4000_0000 + 32'(k * 256), 32'(k + 1));
    run_walk(32'h2000, 16'd160, 32'h0, 32'h0, 1'b0, "R9");
    run_walk(32'h2000, 16'd128, 32'h0, 32'h0, 1'b0, "R9");
    run_walk(32'h2000, 16'd136, 32'h0, 32'h0, 1'b0, "R9");

    // Empty list substitutes the supplied pair (R3).
    run_walk(32'h2000, 16'd0, 32'h5000_0000, 32'h1234, 1'b0, "R3");
    run_walk(32'h2000, 16'd7, 32'h5000_8000, 32'h0, 1'b0, "R3");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule